// File: doc/BRIEF.md
# Instruction Watchdog Runout Trap Unit

This unit bounds the number of clock cycles a processor may spend on a single instruction. Every instruction start strobe reloads an internal cycle counter. If the instruction has not signalled completion when the counter reaches its limit, the unit aborts the instruction and requests a trap to a fixed vector, all in the same pulse.

At the moment of runout the unit records a 4-bit trap condition code. The code shows which of three buses (processor, memory, I/O) was busy, so that trap software can guess the cause of the stall. It also records whether the aborted instruction had already modified a register or a memory word. A runout counts as a processor fault and sets a sticky fault flag, which only an explicit clear input removes.

The surrounding pipeline owns trap entry and the saving of processor state. It samples `trapReq`, `trapVector`, `trapCode` and `regAltered` on the cycle the trap pulse is high.

Top module: `insn_watchdog`

## Requirements
- R1: While `rstN` is low and after its release, before any runout, `abortReq`, `trapReq`, `trapCode`, `regAltered` and `procFault` are 0 and `trapVector` is 0.
- R2: Suppose `insnStart` is sampled high at clock edge E0 with `enable` high, and neither `insnStart` nor `insnDone` is sampled high at edges E1..E(LIMIT). Then `trapReq` and `abortReq` both rise after edge E(LIMIT) and stay high for exactly one cycle. They are never high one without the other.
- R3: `trapVector` equals TRAP_VECTOR (default 8'h46) in every cycle that `trapReq` is high, and 0 otherwise.
- R4: On a runout, `trapCode` is loaded from the bus indicators sampled at edge E(LIMIT). Bit 3 is trap condition 1 and is always 0. Bit 2 is `procBusBusy`, bit 1 is `memBusBusy` and bit 0 is `ioBusBusy`. The value holds until the next runout.
- R5: On a runout, `regAltered` is loaded with 1 if `stateWritten` was sampled high at any edge from the most recent start edge through E(LIMIT), and with 0 otherwise. The value holds until the next runout.
- R6: `procFault` becomes 1 with every trap pulse and stays 1 until `faultClear` is sampled high. If a runout and `faultClear` fall on the same edge, the flag ends up set.
- R7: If `insnDone` is sampled high at any edge E1..E(LIMIT), including the final edge E(LIMIT) on which the runout would otherwise be detected, no trap is raised for that instruction. `trapCode` and `regAltered` then keep their previous values.
- R8: An `insnStart` sampled while an instruction is running restarts the count from zero. The runout then follows LIMIT edges after the new start, and writes seen before the new start no longer count toward R5.
- R9: An edge with `enable` sampled low neither advances the count nor detects a runout. Each such edge inside the window delays the trap by one cycle.
- R10: With no instruction running (after reset, after completion, or after a runout), `insnDone` and idle cycles raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Watchdog counting enable |
| insnStart | input | 1 | Instruction begins (reloads the counter) |
| insnDone | input | 1 | Instruction completes |
| procBusBusy | input | 1 | Processor bus in use |
| memBusBusy | input | 1 | Memory bus in use |
| ioBusBusy | input | 1 | I/O bus in use |
| stateWritten | input | 1 | A register or memory word is written this cycle |
| faultClear | input | 1 | Clears the sticky fault flag |
| abortReq | output | 1 | Abort the current instruction (one-cycle pulse) |
| trapReq | output | 1 | Trap request (one-cycle pulse) |
| trapVector | output | VEC_W | Trap vector address, valid with trapReq |
| trapCode | output | 4 | Trap condition code captured at runout |
| regAltered | output | 1 | Aborted instruction had modified state |
| procFault | output | 1 | Sticky processor-detected fault flag |

## Verification
The assertions assume the inputs are known, 0-or-1 values from reset onward. The bus indicators and `stateWritten` are only meaningful at the sampling edge, so the checks compare captured fields against the previous cycle's inputs. The assertions check abort/trap agreement, pulse width, the vector, the bus-code capture, fault stickiness, and the suppression of a trap by completion, restart or a disabled cycle. The exact LIMIT-cycle window is left to the bench. The bench builds the window with LIMIT=8 and sweeps the following:
- every completion position,
- every bus combination, driving the complement on every other edge so that a wrong sampling edge shows up,
- several write positions,
- disabled gaps and restarts.

Inputs are always driven on the falling edge, so every sampled value is stable at the rising edge.

// File: rtl/insn_watchdog_pkg.sv
`timescale 1ns/1ps
package insn_watchdog_pkg;

  // Strobes sent from the control FSM to the datapath each cycle.
  typedef struct packed {
    logic reload;      // restart count at zero, reset write accumulator
    logic advance;     // increment cycle count
    logic capture;     // runout detected: load code/flags, emit trap pulse
    logic clearFault;  // request to drop the sticky fault flag
  } wdStrobes_t;

  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_RUN  = 1'b1
  } wdState_t;

  localparam int TCODE_W = 4;

endpackage

// File: rtl/insn_watchdog_ctrl.sv
`timescale 1ns/1ps
module insn_watchdog_ctrl
  import insn_watchdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       insnStart,
  input  logic       insnDone,
  input  logic       faultClear,
  input  logic       atLimit,
  output wdStrobes_t strobes
);

  wdState_t state;
  wdState_t stateNext;
  logic     running;
  logic     expire;

  assign running = (state == WD_RUN);

  // Completion and restart both outrank a runout on the same edge.
  assign expire = running && enable && atLimit && !insnDone && !insnStart;

  always_comb begin
    strobes            = '0;
    strobes.reload     = insnStart;
    strobes.advance    = running && enable && !atLimit && !insnStart;
    strobes.capture    = expire;
    strobes.clearFault = faultClear;
  end

  always_comb begin
    stateNext = state;
    if (insnStart) begin
      stateNext = WD_RUN;
    end else if (running && (insnDone || expire)) begin
      stateNext = WD_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= WD_IDLE;
    end else begin
      state <= stateNext;
    end
  end

endmodule

// File: rtl/insn_watchdog_dp.sv
`timescale 1ns/1ps
module insn_watchdog_dp
  import insn_watchdog_pkg::*;
#(
  parameter int          LIMIT       = 256,
  parameter int          VEC_W       = 8,
  parameter logic [VEC_W-1:0] TRAP_VECTOR = 8'h46
) (
  input  logic               clk,
  input  logic               rstN,
  input  wdStrobes_t         strobes,
  input  logic               procBusBusy,
  input  logic               memBusBusy,
  input  logic               ioBusBusy,
  input  logic               stateWritten,
  output logic               atLimit,
  output logic               trapPulse,
  output logic [VEC_W-1:0]   trapVector,
  output logic [TCODE_W-1:0] trapCode,
  output logic               regAltered,
  output logic               procFault
);

  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0]   cycleCnt;
  logic               writeSeen;
  logic [TCODE_W-1:0] busCode;

  assign atLimit = (cycleCnt == LAST_CNT);

  // Condition 1 is forced to 0 on a runout; the remaining bits name the buses.
  assign busCode = {1'b0, procBusBusy, memBusBusy, ioBusBusy};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (strobes.reload) begin
      cycleCnt <= '0;
    end else if (strobes.advance) begin
      cycleCnt <= cycleCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeSeen <= 1'b0;
    end else if (strobes.reload) begin
      writeSeen <= stateWritten;
    end else if (stateWritten) begin
      writeSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapPulse  <= 1'b0;
      trapCode   <= '0;
      regAltered <= 1'b0;
    end else begin
      trapPulse <= strobes.capture;
      if (strobes.capture) begin
        trapCode   <= busCode;
        regAltered <= writeSeen || stateWritten;
      end
    end
  end

  // Setting has priority over clearing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      procFault <= 1'b0;
    end else if (strobes.capture) begin
      procFault <= 1'b1;
    end else if (strobes.clearFault) begin
      procFault <= 1'b0;
    end
  end

  assign trapVector = trapPulse ? TRAP_VECTOR : '0;

endmodule

// File: rtl/insn_watchdog.sv
`timescale 1ns/1ps
module insn_watchdog
  import insn_watchdog_pkg::*;
#(
  parameter int               LIMIT       = 256,
  parameter int               VEC_W       = 8,
  parameter logic [VEC_W-1:0] TRAP_VECTOR = 8'h46
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             insnStart,
  input  logic             insnDone,
  input  logic             procBusBusy,
  input  logic             memBusBusy,
  input  logic             ioBusBusy,
  input  logic             stateWritten,
  input  logic             faultClear,
  output logic             abortReq,
  output logic             trapReq,
  output logic [VEC_W-1:0] trapVector,
  output logic [3:0]       trapCode,
  output logic             regAltered,
  output logic             procFault
);

  wdStrobes_t strobes;
  logic       atLimit;
  logic       trapPulse;

  insn_watchdog_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .insnStart  (insnStart),
    .insnDone   (insnDone),
    .faultClear (faultClear),
    .atLimit    (atLimit),
    .strobes    (strobes)
  );

  insn_watchdog_dp #(
    .LIMIT       (LIMIT),
    .VEC_W       (VEC_W),
    .TRAP_VECTOR (TRAP_VECTOR)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .procBusBusy  (procBusBusy),
    .memBusBusy   (memBusBusy),
    .ioBusBusy    (ioBusBusy),
    .stateWritten (stateWritten),
    .atLimit      (atLimit),
    .trapPulse    (trapPulse),
    .trapVector   (trapVector),
    .trapCode     (trapCode),
    .regAltered   (regAltered),
    .procFault    (procFault)
  );

  // The abort and the trap request are one event seen by two consumers.
  assign abortReq = trapPulse;
  assign trapReq  = trapPulse;

endmodule

// File: rtl/insn_watchdog_chk.sv
`timescale 1ns/1ps
module insn_watchdog_chk #(
  parameter int               VEC_W       = 8,
  parameter logic [VEC_W-1:0] TRAP_VECTOR = 8'h46
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             insnStart,
  input logic             insnDone,
  input logic             procBusBusy,
  input logic             memBusBusy,
  input logic             ioBusBusy,
  input logic             stateWritten,
  input logic             faultClear,
  input logic             abortReq,
  input logic             trapReq,
  input logic [VEC_W-1:0] trapVector,
  input logic [3:0]       trapCode,
  input logic             regAltered,
  input logic             procFault
);

  AST_ABORT_WITH_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    abortReq == trapReq); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> !trapReq); // R2
  AST_VECTOR_ON_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> trapVector == TRAP_VECTOR); // R3
  AST_VECTOR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |-> trapVector == '0); // R3
  AST_COND1_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> !trapCode[3]); // R4
  AST_BUS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> trapCode[2:0] == $past({procBusBusy, memBusBusy, ioBusBusy})); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |=> $stable(trapCode) || trapReq); // R4
  AST_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    trapReq && $past(stateWritten) |-> regAltered); // R5
  AST_FAULT_ON_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> procFault); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    procFault && !faultClear |=> procFault); // R6
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    insnDone |=> !trapReq); // R7
  AST_RESTART_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    insnStart |=> !trapReq); // R8
  AST_DISABLED_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !trapReq); // R9

endmodule

bind insn_watchdog insn_watchdog_chk #(
  .VEC_W       (VEC_W),
  .TRAP_VECTOR (TRAP_VECTOR)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .insnStart    (insnStart),
  .insnDone     (insnDone),
  .procBusBusy  (procBusBusy),
  .memBusBusy   (memBusBusy),
  .ioBusBusy    (ioBusBusy),
  .stateWritten (stateWritten),
  .faultClear   (faultClear),
  .abortReq     (abortReq),
  .trapReq      (trapReq),
  .trapVector   (trapVector),
  .trapCode     (trapCode),
  .regAltered   (regAltered),
  .procFault    (procFault)
);

// File: tb/insn_watchdog_test.sv
`timescale 1ns/1ps
module insn_watchdog_test;

  localparam int LIMIT = 8;
  localparam logic [7:0] VEC = 8'h46;
  localparam int NONE = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic insnStart = 1'b0;
  logic insnDone = 1'b0;
  logic procBusBusy = 1'b0;
  logic memBusBusy = 1'b0;
  logic ioBusBusy = 1'b0;
  logic stateWritten = 1'b0;
  logic faultClear = 1'b0;
  logic abortReq, trapReq, regAltered, procFault;
  logic [7:0] trapVector;
  logic [3:0] trapCode;

  int testsRun = 0;
  int testsFailed = 0;
  logic [3:0] lastCode = 4'h0;
  logic lastAltered = 1'b0;

  always #2 clk = ~clk;

  insn_watchdog #(.LIMIT(LIMIT), .VEC_W(8), .TRAP_VECTOR(VEC)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .insnStart(insnStart),
    .insnDone(insnDone), .procBusBusy(procBusBusy), .memBusBusy(memBusBusy),
    .ioBusBusy(ioBusBusy), .stateWritten(stateWritten), .faultClear(faultClear),
    .abortReq(abortReq), .trapReq(trapReq), .trapVector(trapVector),
    .trapCode(trapCode), .regAltered(regAltered), .procFault(procFault)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One instruction. Edges are counted from the start edge E0.
  //   doneAt    edge index where insnDone is high (NONE = never)
  //   bus       bus indicators at the detection edge (complement elsewhere)
  //   writeAt   edge index of a single stateWritten pulse (NONE = none)
  //   gap       number of edges E1..Egap with enable low
  //   restartAt edge index of a second insnStart (0 = none)
  //   clrAtEnd  drive faultClear at the detection edge
  task automatic runInsn(input int doneAt, input logic [2:0] bus, input int writeAt,
                         input int gap, input int restartAt, input bit clrAtEnd);
    int total;
    int base;
    bit expTrap;
    bit expAlt;
    bit early;
    base = (restartAt > 0) ? restartAt : 0;
    total = base + LIMIT + gap;
    expTrap = (doneAt > total);
    expAlt = (writeAt != NONE) && (writeAt >= base) && (writeAt <= total);
    early = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    insnStart = 1'b1;
    stateWritten = (writeAt == 0);
    {procBusBusy, memBusBusy, ioBusBusy} = ~bus;
    for (int j = 1; j <= total; j++) begin
      @(negedge clk);
      if (trapReq) early = 1'b1;
      insnStart = (j == restartAt);
      insnDone = (j == doneAt);
      stateWritten = (j == writeAt);
      enable = !(j >= 1 && j <= gap);
      faultClear = clrAtEnd && (j == total);
      {procBusBusy, memBusBusy, ioBusBusy} = (j == total) ? bus : ~bus;
    end
    @(negedge clk);
    {insnStart, insnDone, stateWritten, faultClear} = '0;
    enable = 1'b1;
    check(!early, "R2 no trap before window end", int'(early), 0);
    check(trapReq == expTrap, expTrap ? "R2 trap at window end" : "R7 done suppresses trap",
          int'(trapReq), int'(expTrap));
    check(abortReq == expTrap, "R2 abort at window end", int'(abortReq), int'(expTrap));
    check(trapVector == (expTrap ? VEC : 8'h00), "R3 vector", int'(trapVector),
          int'(expTrap ? VEC : 8'h00));
    if (expTrap) begin
      lastCode = {1'b0, bus};
      lastAltered = expAlt;
      check(procFault, "R6 fault set by runout", int'(procFault), 1);
    end
    check(trapCode == lastCode, expTrap ? "R4 bus code" : "R7 code held",
          int'(trapCode), int'(lastCode));
    check(regAltered == lastAltered, expTrap ? "R5 altered flag" : "R7 altered held",
          int'(regAltered), int'(lastAltered));
    @(negedge clk);
    check(!trapReq && !abortReq, "R2 one-cycle pulse", int'(trapReq), 0);
    check(trapCode == lastCode, "R4 code holds after pulse", int'(trapCode), int'(lastCode));
  endtask

  task automatic clearFault();
    @(negedge clk);
    faultClear = 1'b1;
    @(negedge clk);
    faultClear = 1'b0;
    check(!procFault, "R6 clear drops fault", int'(procFault), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!trapReq && !abortReq && trapCode == 0 && !regAltered && !procFault && trapVector == 0,
          "R1 outputs in reset", int'(trapCode), 0);
    rstN = 1'b1;
    enable = 1'b1;
    repeat (LIMIT + 3) @(negedge clk);
    check(!trapReq && !procFault && trapCode == 0, "R1 quiet after reset", int'(trapReq), 0);

    // R10: stray completion with nothing running
    insnDone = 1'b1;
    @(negedge clk);
    insnDone = 1'b0;
    repeat (LIMIT + 2) begin
      @(negedge clk);
      check(!trapReq, "R10 idle raises no trap", int'(trapReq), 0);
    end

    // R2 R4 R5: every bus pattern with several write positions
    for (int b = 0; b < 8; b++) begin
      runInsn(NONE, 3'(b), NONE, 0, 0, 1'b0);
      runInsn(NONE, 3'(b), 0, 0, 0, 1'b0);
      runInsn(NONE, 3'(~b), 3, 0, 0, 1'b0);
      runInsn(NONE, 3'(b), LIMIT, 0, 0, 1'b0);
    end

    // R6: the flag stays until cleared
    repeat (4) @(negedge clk);
    check(procFault, "R6 fault sticky", int'(procFault), 1);
    clearFault();

    // R7: completion at every edge of the window, including the last
    for (int d = 1; d <= LIMIT; d++) begin
      runInsn(d, 3'b101, 2, 0, 0, 1'b0);
      check(!procFault, "R7 no fault after completion", int'(procFault), 0);
    end

    // R10: after completion and after a runout no further trap follows
    runInsn(3, 3'b010, NONE, 0, 0, 1'b0);
    repeat (LIMIT + 2) @(negedge clk);
    check(!trapReq, "R10 no trap after completion", int'(trapReq), 0);
    runInsn(NONE, 3'b010, NONE, 0, 0, 1'b0);
    repeat (LIMIT + 2) @(negedge clk);
    check(!trapReq, "R10 no trap after runout", int'(trapReq), 0);

    // R6: runout and clear on the same edge leave the flag set
    clearFault();
    runInsn(NONE, 3'b111, NONE, 0, 0, 1'b1);
    check(procFault, "R6 set beats clear", int'(procFault), 1);
    clearFault();

    // R9: disabled edges delay the runout
    for (int g = 1; g <= 5; g += 2) begin
      runInsn(NONE, 3'b011, NONE, g, 0, 1'b0);
      runInsn(LIMIT + g, 3'b100, NONE, g, 0, 1'b0);
    end

    // R8: restart mid-instruction; writes before the restart are forgotten
    for (int r = 1; r <= LIMIT - 1; r += 3) begin
      runInsn(NONE, 3'b110, r - 1, 0, r, 1'b0);
      runInsn(NONE, 3'b001, r + 1, 0, r, 1'b0);
    end
    runInsn(NONE, 3'b000, 0, 0, LIMIT, 1'b0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(4 * 20000);
    testsFailed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule